// File: doc/BRIEF.md
# Single-Wire Master Read-Slot and Program-Pulse Timer

This block is the timing core of a master on a single-wire serial bus. The bus is open-drain and pulled up. The block runs two operations, one at a time.

- **Read slot.** The block pulls the line low briefly and then releases it. It samples the bit returned by the slave late in the slave's data-valid window, keeps the line released for the rest of the slot and for a recovery gap, and then signals completion.
- **Program pulse.** The block raises an enable for the external high-voltage programming driver for a fixed time. It does this only when the caller confirms that the CRC of the current byte was good.

All durations are set in microseconds and turned into clock cycles using a clock-frequency parameter. Parameter values outside the legal bus timing are rejected at elaboration. The caller starts an operation with a single-cycle command while the block reports ready. It then waits for the done strobe and reads the sampled bit.

Top module: `ow_slot_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `drive_low_o`, `prog_en_o`, `done_o`, `err_o` and `bit_o` are 0 and `ready_o` is 1.
- R2: A read command (`cmd_valid_i`=1, `cmd_prog_i`=0) accepted while ready makes `drive_low_o` go high in the next cycle. It stays high for exactly LOW_US·CLK_HZ/1e6 cycles (300 by default).
- R3: Count the first cycle of `drive_low_o` as cycle 0. `bit_o` keeps its old value up to cycle SAMPLE_US·CLK_HZ/1e6−1. From cycle SAMPLE_US·CLK_HZ/1e6 (700) it shows the line level sampled inside the window (0 = slave held the line low, 1 = line high).
- R4: `done_o` is high for exactly one cycle, at cycle (SLOT_US+REC_US)·CLK_HZ/1e6 (3500). `drive_low_o` stays low from the end of the low pulse until then. `ready_o` returns to 1 in that same cycle.
- R5: `bit_o` does not change while `ready_o` is 1.
- R6: A program command (`cmd_prog_i`=1) accepted with `crc_ok_i`=1 raises `prog_en_o` in the next cycle for exactly PROG_US·CLK_HZ/1e6 cycles (24000). `done_o` pulses in the cycle after `prog_en_o` falls.
- R7: A program command with `crc_ok_i`=0 starts nothing. `err_o` pulses for one cycle in the next cycle, `ready_o` stays 1, and `prog_en_o` stays 0.
- R8: `cmd_valid_i` while `ready_o` is 0 is ignored. The running operation keeps its timing and `err_o` stays 0.
- R9: `drive_low_o` and `prog_en_o` are never high together. `prog_en_o` rises only after an accepted, CRC-confirmed program command.
- R10: A command presented in the cycle that `done_o` pulses is accepted, and the next operation starts in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command strobe, taken when ready_o is 1 |
| cmd_prog_i | input | 1 | 0 = read slot, 1 = program pulse |
| crc_ok_i | input | 1 | CRC of current byte confirmed |
| line_i | input | 1 | Bus line level |
| ready_o | output | 1 | Engine idle, command can be taken |
| drive_low_o | output | 1 | Pull the line low (open-drain) |
| prog_en_o | output | 1 | Enable the programming-voltage driver |
| bit_o | output | 1 | Last sampled read bit |
| done_o | output | 1 | One-cycle completion strobe |
| err_o | output | 1 | Program refused: CRC not confirmed |

## Verification
The end of one operation and the acceptance of the next can fall in the same cycle. `done_o` and `ready_o` rise together, so a new command presented then must start at once without losing the strobe. The bench issues a read immediately in the done cycle of a program pulse, and a program immediately after a read. It checks that the new drive or enable appears exactly one cycle later. A second overlap is a program request that lands in the middle of a read slot. The bench checks that it leaves the slot timing, `prog_en_o` and `err_o` untouched.

// File: rtl/ow_pkg.sv
package ow_pkg;
  typedef enum logic [1:0] {RS_IDLE, RS_LOW, RS_WAIT, RS_REC} rd_state_e;

  function automatic int unsigned us_to_cyc(longint unsigned hz, int unsigned us);
    return int'((hz * longint'(us)) / 64'd1000000);
  endfunction
endpackage

// File: rtl/ow_line_sync.sv
module ow_line_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [1:0] sync_q;

  // reset to the pulled-up idle level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], line_i};
  end

  assign line_o = sync_q[1];
endmodule

// File: rtl/ow_read_slot.sv
module ow_read_slot #(
  parameter int unsigned LOW_C  = 300,
  parameter int unsigned SAMP_C = 700,
  parameter int unsigned SLOT_C = 3250,
  parameter int unsigned REC_C  = 250
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic line_i,
  output logic drive_low_o,
  output logic busy_o,
  output logic bit_o,
  output logic done_o
);
  import ow_pkg::*;

  localparam int unsigned MAXC = (SLOT_C > REC_C) ? SLOT_C : REC_C;
  localparam int unsigned CW   = $clog2(MAXC + 1);

  rd_state_e       state_q;
  logic [CW-1:0]   cnt_q;
  logic            bit_q;
  logic            done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RS_IDLE;
      cnt_q   <= '0;
      bit_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        RS_IDLE: if (start_i) begin
          state_q <= RS_LOW;
          cnt_q   <= '0;
        end
        RS_LOW: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(LOW_C - 1)) state_q <= RS_WAIT;
        end
        RS_WAIT: begin
          cnt_q <= cnt_q + 1'b1;
          // latest sample point still inside the data-valid window
          if (cnt_q == CW'(SAMP_C - 1)) bit_q <= line_i;
          if (cnt_q == CW'(SLOT_C - 1)) begin
            state_q <= RS_REC;
            cnt_q   <= '0;
          end
        end
        RS_REC: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CW'(REC_C - 1)) begin
            state_q <= RS_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= RS_IDLE;
      endcase
    end
  end

  assign drive_low_o = (state_q == RS_LOW);
  assign busy_o      = (state_q != RS_IDLE);
  assign bit_o       = bit_q;
  assign done_o      = done_q;
endmodule

// File: rtl/ow_prog_pulse.sv
module ow_prog_pulse #(
  parameter int unsigned PROG_C = 24000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic en_o,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = $clog2(PROG_C + 1);

  logic          act_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!act_q) begin
        if (start_i) begin
          act_q <= 1'b1;
          cnt_q <= '0;
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CW'(PROG_C - 1)) begin
          act_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign en_o   = act_q;
  assign busy_o = act_q;
  assign done_o = done_q;
endmodule

// File: rtl/ow_slot_engine.sv
module ow_slot_engine #(
  parameter longint unsigned CLK_HZ = 50_000_000,
  parameter int unsigned LOW_US    = 6,
  parameter int unsigned SAMPLE_US = 14,
  parameter int unsigned SLOT_US   = 65,
  parameter int unsigned REC_US    = 5,
  parameter int unsigned PROG_US   = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_valid_i,
  input  logic cmd_prog_i,
  input  logic crc_ok_i,
  input  logic line_i,
  output logic ready_o,
  output logic drive_low_o,
  output logic prog_en_o,
  output logic bit_o,
  output logic done_o,
  output logic err_o
);
  import ow_pkg::*;

  localparam int unsigned LOW_C  = us_to_cyc(CLK_HZ, LOW_US);
  localparam int unsigned SAMP_C = us_to_cyc(CLK_HZ, SAMPLE_US);
  localparam int unsigned SLOT_C = us_to_cyc(CLK_HZ, SLOT_US);
  localparam int unsigned REC_C  = us_to_cyc(CLK_HZ, REC_US);
  localparam int unsigned PROG_C = us_to_cyc(CLK_HZ, PROG_US);

  localparam bit PARAM_OK = (LOW_US >= 1) && (LOW_US < 15) &&
                            (SAMPLE_US > LOW_US) && (SAMPLE_US < 15) &&
                            (SLOT_US >= 60) && (SLOT_US < 120) &&
                            (REC_US >= 1) && (PROG_US >= 1) && (LOW_C >= 1);

  generate
    if (!PARAM_OK) begin : g_bad_timing
      $error("ow_slot_engine: timing parameters outside legal bus range");
    end
  endgenerate

  logic line_s;
  logic rd_busy, rd_done, pg_busy, pg_done;
  logic idle, rd_start, pg_start, pg_refuse;
  logic err_q;

  assign idle      = !rd_busy && !pg_busy;
  assign rd_start  = idle && cmd_valid_i && !cmd_prog_i;
  assign pg_start  = idle && cmd_valid_i &&  cmd_prog_i &&  crc_ok_i;
  assign pg_refuse = idle && cmd_valid_i &&  cmd_prog_i && !crc_ok_i;

  ow_line_sync u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (line_i),
    .line_o (line_s)
  );

  ow_read_slot #(
    .LOW_C  (LOW_C),
    .SAMP_C (SAMP_C),
    .SLOT_C (SLOT_C),
    .REC_C  (REC_C)
  ) u_rd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (rd_start),
    .line_i      (line_s),
    .drive_low_o (drive_low_o),
    .busy_o      (rd_busy),
    .bit_o       (bit_o),
    .done_o      (rd_done)
  );

  ow_prog_pulse #(
    .PROG_C (PROG_C)
  ) u_pg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (pg_start),
    .en_o    (prog_en_o),
    .busy_o  (pg_busy),
    .done_o  (pg_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= pg_refuse;
  end

  assign ready_o = idle;
  assign done_o  = rd_done | pg_done;
  assign err_o   = err_q;
endmodule

// File: rtl/ow_slot_engine_chk.sv
module ow_slot_engine_chk #(
  parameter int unsigned LOW_C  = 300,
  parameter int unsigned PROG_C = 24000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic cmd_valid_i,
  input logic cmd_prog_i,
  input logic crc_ok_i,
  input logic ready_o,
  input logic drive_low_o,
  input logic prog_en_o,
  input logic bit_o,
  input logic done_o,
  input logic err_o
);
  int unsigned lo_run, pg_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_run <= 0;
      pg_run <= 0;
    end else begin
      lo_run <= drive_low_o ? lo_run + 1 : 0;
      pg_run <= prog_en_o   ? pg_run + 1 : 0;
    end
  end

  a_r9_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drive_low_o && prog_en_o));

  a_r9_prog_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prog_en_o) |-> $past(ready_o && cmd_valid_i && cmd_prog_i && crc_ok_i));

  a_r7_err_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(ready_o && cmd_valid_i && cmd_prog_i && !crc_ok_i));

  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r2_low_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_run <= LOW_C);

  a_r2_low_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(drive_low_o) |-> lo_run == LOW_C);

  a_r6_prog_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(prog_en_o) |-> (pg_run == PROG_C) && done_o);

  a_r5_bit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && $past(ready_o)) |-> $stable(bit_o));
endmodule

bind ow_slot_engine ow_slot_engine_chk #(
  .LOW_C  (LOW_C),
  .PROG_C (PROG_C)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_prog_i  (cmd_prog_i),
  .crc_ok_i    (crc_ok_i),
  .ready_o     (ready_o),
  .drive_low_o (drive_low_o),
  .prog_en_o   (prog_en_o),
  .bit_o       (bit_o),
  .done_o      (done_o),
  .err_o       (err_o)
);

// File: tb/ow_slot_engine_test.sv
module ow_slot_engine_test;
  localparam int CPU   = 50;          // cycles per microsecond at 50 MHz
  localparam int LOW_C  = 6 * CPU;
  localparam int SAMP_C = 14 * CPU;
  localparam int SLOT_C = 65 * CPU;
  localparam int REC_C  = 5 * CPU;
  localparam int PROG_C = 480 * CPU;
  localparam int VALID_C = 15 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_prog = 1'b0, crc_ok = 1'b0;
  logic ready, drive_low, prog_en, bit_out, done, err;
  logic slave_low = 1'b0;
  logic slave_bit = 1'b1;
  int   slave_rel = 0;
  wire  line = !(drive_low || slave_low);

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ow_slot_engine uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cmd_valid_i (cmd_valid),
    .cmd_prog_i  (cmd_prog),
    .crc_ok_i    (crc_ok),
    .line_i      (line),
    .ready_o     (ready),
    .drive_low_o (drive_low),
    .prog_en_o   (prog_en),
    .bit_o       (bit_out),
    .done_o      (done),
    .err_o       (err)
  );

  // slave: on master fall, hold a zero through the valid window plus a release delay
  initial forever begin
    @(posedge drive_low);
    if (!slave_bit) begin
      slave_low = 1'b1;
      repeat (VALID_C + slave_rel) @(posedge clk);
      slave_low = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_bit_cycle(input int t, input bit old_b, input bit new_b);
    return (t < SAMP_C) ? int'(old_b) : int'(new_b);
  endfunction

  // called at a negedge; presents the command in that cycle
  task automatic do_read(input bit b, input int rel, input bit poke);
    bit old_b = bit_out;
    bit bit_ok = 1'b1;
    bit idle_ok = 1'b1;
    int t = 0;
    int n = 0;
    slave_bit = b;
    slave_rel = rel;
    cmd_valid = 1'b1; cmd_prog = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(done == 1'b0, "R4 done single cycle", int'(done), 0);
    chk(drive_low == 1'b1 && ready == 1'b0, "R2 drive starts next cycle", int'(drive_low), 1);
    while (drive_low && n < LOW_C + 10) begin
      if (int'(bit_out) != exp_bit_cycle(t, old_b, b)) bit_ok = 1'b0;
      n++; t++;
      @(negedge clk);
    end
    chk(n == LOW_C, "R2 low pulse width", n, LOW_C);
    while (!done && t < SLOT_C + REC_C + 10) begin
      if (int'(bit_out) != exp_bit_cycle(t, old_b, b)) bit_ok = 1'b0;
      if (drive_low || prog_en || err) idle_ok = 1'b0;
      if (poke && t == 1000) begin cmd_valid = 1'b1; cmd_prog = 1'b1; crc_ok = 1'b1; end
      else cmd_valid = 1'b0;
      t++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
    chk(t == SLOT_C + REC_C, "R4 slot plus recovery length", t, SLOT_C + REC_C);
    chk(idle_ok, poke ? "R8 busy command ignored" : "R4 line released after low", int'(idle_ok), 1);
    chk(bit_ok, "R3 bit timing", int'(bit_out), int'(b));
    chk(bit_out == b && ready, "R3 sampled bit", int'(bit_out), int'(b));
  endtask

  task automatic do_prog(input bit crc);
    bit hold = bit_out;
    bit ok = 1'b1;
    int n = 0;
    cmd_valid = 1'b1; cmd_prog = 1'b1; crc_ok = crc;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (crc) begin
      chk(prog_en == 1'b1 && ready == 1'b0, "R6 enable starts next cycle", int'(prog_en), 1);
      while (prog_en && n < PROG_C + 10) begin
        if (drive_low) ok = 1'b0;
        n++;
        @(negedge clk);
      end
      chk(n == PROG_C, "R6 program pulse width", n, PROG_C);
      chk(ok, "R9 no drive during program", int'(ok), 1);
      chk(done == 1'b1 && ready == 1'b1, "R6 done after pulse", int'(done), 1);
      chk(bit_out == hold, "R5 bit held over program", int'(bit_out), int'(hold));
    end else begin
      chk(err == 1'b1, "R7 error pulse", int'(err), 1);
      chk(ready == 1'b1 && prog_en == 1'b0 && !done, "R7 refused program idle", int'(prog_en), 0);
      @(negedge clk);
      chk(err == 1'b0, "R7 error single cycle", int'(err), 0);
      repeat (20) begin
        if (prog_en || drive_low || !ready) ok = 1'b0;
        @(negedge clk);
      end
      chk(ok, "R7 nothing started", int'(ok), 1);
      chk(bit_out == hold, "R5 bit held while ready", int'(bit_out), int'(hold));
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h1d5eed);
    repeat (3) @(negedge clk);
    chk(!drive_low && !prog_en && !done && !err && !bit_out && ready, "R1 reset state",
        int'({drive_low, prog_en, done, err, bit_out}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!drive_low && !prog_en && !done && !err && ready, "R1 after reset",
        int'({drive_low, prog_en, done, err}), 0);

    do_read(1'b0, 0, 1'b0);          // earliest slave release
    @(negedge clk);
    do_read(1'b1, 0, 1'b0);
    @(negedge clk);
    do_read(1'b0, 45 * CPU, 1'b0);   // latest slave release
    @(negedge clk);
    do_prog(1'b0);
    do_read(1'b1, 0, 1'b1);          // program request lands mid-slot
    do_prog(1'b1);                   // R10: presented in read done cycle
    do_read(1'b0, 10 * CPU, 1'b0);   // R10: presented in program done cycle
    chk(1'b1, "R10 back-to-back accepted", 1, 1);
    for (int i = 0; i < 12; i++) begin
      bit rb = 1'($urandom);
      int rl = int'($urandom % (45 * CPU + 1));
      if (($urandom % 3) != 0) @(negedge clk);
      do_read(rb, rl, 1'b0);
    end
    @(negedge clk);
    chk(!done, "R4 done cleared", int'(done), 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule